// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Selector

This block keeps the replacement state for an eight-way set-associative cache and names the way to evict when the cache needs to allocate. Each set has a seven-bit binary tree. The root chooses between ways 0–3 and ways 4–7. Two middle bits each choose a pair within a half. Four leaf bits each choose one way within a pair. Every hit or fill turns the bits on the used way's path toward the other subtree. A later walk from the root therefore lands on a way that has not been used recently.

The surrounding cache controller presents a set index with a hit strobe, a fill strobe, or both, plus the way number involved. To ask for a victim, it raises a victim-request strobe. The answer comes back one cycle later as a valid flag and a way number. Two software controls gate the block. The enable input turns off all allocation. The lock input freezes the cache so that nothing is ever replaced. Tags and data storage belong to the controller.

Top module: `plru8_repl`

## Requirements
- R1: After reset every tree bit of every set is 0, `vic_vld` is 0, and the first victim reported for any set is way 0.
- R2: When `vic_req` is 1 with `en`=1 and `lock`=0, the next cycle shows `vic_vld`=1 and the way found by the tree walk. The walk takes way bit 2 from tree bit 0, way bit 1 from tree bit 1 (left half) or bit 2 (right half), and way bit 0 from tree bit 3+{way bit 2, way bit 1}. In any cycle without a valid victim, `vic_way` is 0.
- R3: A hit on way w, with `en`=1 and `lock`=0, sets tree bit 0 to ~w[2], sets bit 1+w[2] to ~w[1], and sets bit 3+w[2:1] to ~w[0]. All other bits keep their values.
- R4: A fill on way w updates the indexed set in exactly the way R3 describes for a hit.
- R5: When a hit and a fill arrive in the same cycle, only the fill way updates the tree and the hit is dropped.
- R6: A victim request in the same cycle as an update to the same set returns the victim from the tree as it stood before that update.
- R7: While `lock` is 1, a victim request returns `vic_vld`=0 and `vic_way`=0, and hits and fills leave every tree bit unchanged.
- R8: While `en` is 0, a victim request returns `vic_vld`=0 and `vic_way`=0, and hits and fills leave every tree bit unchanged.
- R9: An update changes only the set named by `idx`.
- R10: A victim requested for a set in the cycle after that set was updated is never the way just used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Cache enable; 0 blocks allocation and updates |
| lock | input | 1 | Cache lock; 1 blocks replacement and updates |
| idx | input | 7 | Set index for this cycle's strobes |
| hit_vld | input | 1 | Hit strobe |
| hit_way | input | 3 | Way that hit |
| fill_vld | input | 1 | Fill strobe |
| fill_way | input | 3 | Way being filled |
| vic_req | input | 1 | Victim request strobe |
| vic_vld | output | 1 | Victim valid, one cycle after request |
| vic_way | output | 3 | Victim way, 0 when not valid |

## Verification
The tree state of a frozen cache cannot be seen from the ports, because a locked or disabled block refuses every victim request. To check the freeze, the stimulus first builds a known tree. It then sends hits and fills while locked and again while disabled. Finally it reopens the block and sweeps victim requests over the touched sets, comparing each answer with the model's unchanged tree. The random phase toggles lock and enable only rarely, so that long stretches of real updates come between the frozen intervals.

// File: rtl/plru8_repl.sv
module plru8_repl #(
  parameter int SETS = 128,
  localparam int IW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          lock,
  input  logic [IW-1:0] idx,
  input  logic          hit_vld,
  input  logic [2:0]    hit_way,
  input  logic          fill_vld,
  input  logic [2:0]    fill_way,
  input  logic          vic_req,
  output logic          vic_vld,
  output logic [2:0]    vic_way
);

  logic [SETS-1:0][6:0] tree_q;

  wire       open_q = en & ~lock;
  wire [2:0] uway   = fill_vld ? fill_way : hit_way;
  wire       do_upd = open_q & (fill_vld | hit_vld);
  wire [6:0] cur    = tree_q[idx];

  function automatic logic [6:0] touch(input logic [6:0] t, input logic [2:0] w);
    logic [6:0] r;
    r = t;
    r[0] = ~w[2];
    if (w[2]) r[2] = ~w[1];
    else      r[1] = ~w[1];
    case (w[2:1])
      2'd0:    r[3] = ~w[0];
      2'd1:    r[4] = ~w[0];
      2'd2:    r[5] = ~w[0];
      default: r[6] = ~w[0];
    endcase
    return r;
  endfunction

  function automatic logic [2:0] walk(input logic [6:0] t);
    logic [2:0] w;
    w[2] = t[0];
    w[1] = w[2] ? t[2] : t[1];
    case (w[2:1])
      2'd0:    w[0] = t[3];
      2'd1:    w[0] = t[4];
      2'd2:    w[0] = t[5];
      default: w[0] = t[6];
    endcase
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      tree_q <= '0;
    else if (do_upd) tree_q[idx] <= touch(cur, uway);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_vld <= 1'b0;
      vic_way <= 3'd0;
    end else begin
      vic_vld <= vic_req & open_q;
      vic_way <= (vic_req & open_q) ? walk(cur) : 3'd0;
    end
  end

endmodule

// File: rtl/plru8_repl_chk.sv
module plru8_repl_chk #(
  parameter int SETS = 128,
  localparam int IW = $clog2(SETS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 lock,
  input logic [IW-1:0]        idx,
  input logic                 hit_vld,
  input logic [2:0]           hit_way,
  input logic                 fill_vld,
  input logic [2:0]           fill_way,
  input logic                 vic_req,
  input logic                 vic_vld,
  input logic [2:0]           vic_way,
  input logic [SETS-1:0][6:0] tree_q
);

  assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vic_vld |-> $past(vic_req));

  assert_idle_way_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_vld |-> vic_way == 3'd0);

  assert_locked_no_victim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> !vic_vld);

  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> tree_q == $past(tree_q));

  assert_off_no_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !vic_vld);

  assert_off_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> tree_q == $past(tree_q));

  assert_fresh_not_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_vld && $past(hit_vld || fill_vld, 2) && $past(en && !lock, 2)
     && $past(idx, 2) == $past(idx, 1))
    |-> vic_way != ($past(fill_vld, 2) ? $past(fill_way, 2) : $past(hit_way, 2)));

endmodule

bind plru8_repl plru8_repl_chk #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .lock(lock), .idx(idx),
  .hit_vld(hit_vld), .hit_way(hit_way), .fill_vld(fill_vld), .fill_way(fill_way),
  .vic_req(vic_req), .vic_vld(vic_vld), .vic_way(vic_way), .tree_q(tree_q)
);

// File: tb/sim_plru8_repl.sv
module sim_plru8_repl;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 128;

  logic clk = 0, rst_n = 0, en = 1, lock = 0;
  logic [6:0] idx = 0;
  logic hit_vld = 0, fill_vld = 0, vic_req = 0;
  logic [2:0] hit_way = 0, fill_way = 0;
  logic vic_vld;
  logic [2:0] vic_way;

  int checks = 0, errors = 0;
  logic [6:0] m [SETS];
  logic exp_vld;
  logic [2:0] exp_way;

  plru8_repl #(.SETS(SETS)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] f_touch(logic [6:0] t, logic [2:0] w);
    logic [6:0] r = t;
    r[0] = ~w[2];
    r[1 + w[2]] = ~w[1];
    r[3 + 2*w[2] + w[1]] = ~w[0];
    return r;
  endfunction

  function automatic logic [2:0] f_walk(logic [6:0] t);
    logic b2 = t[0];
    logic b1 = t[1 + b2];
    logic b0 = t[3 + 2*b2 + b1];
    return {b2, b1, b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    bit open = en && !lock;
    exp_vld = vic_req && open;
    exp_way = exp_vld ? f_walk(m[idx]) : 3'd0;
    if (open && fill_vld)     m[idx] = f_touch(m[idx], fill_way);
    else if (open && hit_vld) m[idx] = f_touch(m[idx], hit_way);
    @(posedge clk);
    @(negedge clk);
    chk(vic_vld === exp_vld, {tag, " vld"}, int'(vic_vld), int'(exp_vld));
    chk(vic_way === exp_way, {tag, " way"}, int'(vic_way), int'(exp_way));
    hit_vld = 0; fill_vld = 0; vic_req = 0;
  endtask

  task automatic ask(input logic [6:0] s, input string tag);
    idx = s; vic_req = 1; cycle(tag);
  endtask

  task automatic hit(input logic [6:0] s, input logic [2:0] w, input string tag);
    idx = s; hit_vld = 1; hit_way = w; cycle(tag);
  endtask

  task automatic fill(input logic [6:0] s, input logic [2:0] w, input string tag);
    idx = s; fill_vld = 1; fill_way = w; cycle(tag);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < SETS; i++) m[i] = 7'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(vic_vld === 1'b0, "R1 reset vld", int'(vic_vld), 0);
    ask(7'd5, "R1 first victim");
    ask(7'd127, "R1 first victim top set");

    hit(7'd3, 3'd0, "R3 hit way0");
    ask(7'd3, "R3 R10 victim after hit");
    chk(exp_way == 3'd4, "R3 model", int'(exp_way), 4);
    for (int w = 0; w < 8; w++) begin
      fill(7'd4, w[2:0], "R4 fill");
      ask(7'd4, "R4 R10 victim after fill");
    end
    ask(7'd6, "R9 untouched set");

    idx = 7'd9; hit_vld = 1; hit_way = 3'd7; fill_vld = 1; fill_way = 3'd2;
    cycle("R5 hit+fill");
    ask(7'd9, "R5 fill wins");

    idx = 7'd9; hit_vld = 1; hit_way = 3'd6; vic_req = 1;
    cycle("R6 same-cycle old state");
    ask(7'd9, "R6 new state");

    lock = 1;
    ask(7'd9, "R7 locked request");
    hit(7'd9, 3'd1, "R7 locked hit");
    fill(7'd3, 3'd5, "R7 locked fill");
    lock = 0;
    ask(7'd9, "R7 unchanged set9");
    ask(7'd3, "R7 unchanged set3");

    en = 0;
    ask(7'd4, "R8 disabled request");
    fill(7'd4, 3'd3, "R8 disabled fill");
    hit(7'd4, 3'd6, "R8 disabled hit");
    en = 1;
    ask(7'd4, "R8 unchanged set4");

    for (int n = 0; n < 4000; n++) begin
      idx = 7'($urandom_range(0, 15));
      hit_vld = $urandom_range(0, 2) == 0;
      hit_way = 3'($urandom);
      fill_vld = $urandom_range(0, 3) == 0;
      fill_way = 3'($urandom);
      vic_req = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 49) == 0) lock = ~lock;
      if ($urandom_range(0, 59) == 0) en = ~en;
      cycle("R2 R9 random");
    end
    lock = 0; en = 1;
    for (int s = 0; s < 16; s++) ask(7'(s), "R2 final sweep");
    finish_run();
  end
endmodule